// File: doc/BRIEF.md
# Per-Pad GPIO Output Routing Bank

This block owns the output side of a bank of general-purpose pads. Every pad has two word-wide select registers: one chooses where the pad's output level comes from, the other chooses where its active-low drive enable comes from. Either select can pick an internal peripheral signal. It can also pick a constant 0 or a constant 1, which lets software drive the pad as a plain GPIO. A flag in the top bit of each select register inverts the chosen signal on its way to the pad.

The live pad levels come back through two packed status words, one bit per pad, after a synchronizer. Software reaches all registers over a simple bus: a write takes effect at the clock edge, and read data is valid in the same cycle as the address. The routing from select register to pad is combinational, so a peripheral's output reaches the pad with no added cycle.

Top module: `gpio_route_bank`

## Requirements
- R1: During and after reset, every data select reads 0x00000000 and every enable select reads 0x00000001, so every pad_out is 0 and every pad_oe_n is 1.
- R2: The data select for pad n (0..63) sits at byte offset 0x50 + 8n and the enable select at 0x54 + 8n. Address bits [1:0] are ignored. A write changes only the addressed register.
- R3: A select register reads back with the invert flag in bit 31 and the source code in bits [4:0]. Bits [30:5] always read 0 whatever was written.
- R4: Source code 0 selects constant 0 and code 1 selects constant 1.
- R5: Source code k, with 2 <= k <= 21, selects periph_do[k-2] for a data select and periph_de[k-2] for an enable select.
- R6: Source codes 22 to 31 select constant 0.
- R7: When bit 31 of a select register is 1, the selected value is inverted before it reaches the pad.
- R8: pad_oe_n carries the effective enable value unchanged: 0 drives the pad and 1 tristates it.
- R9: Offset 0x48 returns pad_in[31:0] and offset 0x4C returns pad_in[63:32]. Each level appears after two rising clock edges and not after one.
- R10: Writes to 0x48, 0x4C or any unmapped offset change no register. Reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| periph_do | input | 20 | Peripheral output-value signals |
| periph_de | input | 20 | Peripheral output-enable signals (active low) |
| pad_in | input | 64 | Raw pad input levels |
| pad_out | output | 64 | Output value to each pad |
| pad_oe_n | output | 64 | Active-low drive enable to each pad |

## Verification
A wrong stored select code or a bad address decode shows up on the pad pins in the cycle right after the write that caused it. It also shows up as a wrong readback on the next read of that offset. A decode fault that hits the wrong pad leaves that neighbour's pin moving when it should stay at its reset level, so the bench watches untouched pads as well. A synchronizer with the wrong depth is caught by sampling the status words both one edge and two edges after pad_in changes.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;

   // Word indices (byte offset >> 2) of the register regions
   localparam int unsigned IN_LO_WORD    = 18;   // 0x48
   localparam int unsigned IN_HI_WORD    = 19;   // 0x4C
   localparam int unsigned SEL_BASE_WORD = 20;   // 0x50

   localparam int unsigned BUS_W   = 32;
   localparam int unsigned INV_BIT = 31;

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_STATUS,
      ACC_DSEL,
      ACC_ESEL
   } acc_kind_e;

endpackage

// File: rtl/gpio_route_sync.sv
module gpio_route_sync #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_route_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) begin
            stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_route_srcmux.sv
module gpio_route_srcmux #(
   parameter int unsigned NUM_SRC = 20,
   parameter int unsigned SEL_W   = 5
) (
   input  logic [SEL_W-1:0]   code,
   input  logic               inv,
   input  logic [NUM_SRC-1:0] src,
   output logic               y
);

   localparam int unsigned CODES = NUM_SRC + 2;
   localparam int unsigned SPAN  = 1 << SEL_W;
   localparam bit          FULL  = (CODES == SPAN);

   if (CODES > SPAN) begin : g_bad_width
      $error("gpio_route_srcmux: SEL_W too narrow for NUM_SRC");
   end

   // Code 0 -> constant 0, code 1 -> constant 1, code k -> src[k-2]
   logic [CODES-1:0] cand;
   logic             picked;

   assign cand = {src, 1'b1, 1'b0};

   if (FULL) begin : g_full
      assign picked = cand[code];
   end else begin : g_part
      // Codes past the last source land on zero padding
      logic [SPAN-1:0] cand_ext;
      assign cand_ext = SPAN'(cand);
      assign picked   = cand_ext[code];
   end

   assign y = picked ^ inv;

endmodule

// File: rtl/gpio_route_regs.sv
module gpio_route_regs
   import gpio_route_pkg::*;
#(
   parameter int unsigned NUM_PADS = 64,
   parameter int unsigned SEL_W    = 5,
   parameter int unsigned ADDR_W   = 12
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                bus_addr,
   input  logic                             bus_we,
   input  logic [BUS_W-1:0]                 bus_wdata,
   output logic [BUS_W-1:0]                 bus_rdata,
   input  logic [BUS_W-1:0]                 status_lo,
   input  logic [BUS_W-1:0]                 status_hi,
   output logic [NUM_PADS-1:0][SEL_W-1:0]   dsel_code,
   output logic [NUM_PADS-1:0]              dsel_inv,
   output logic [NUM_PADS-1:0][SEL_W-1:0]   esel_code,
   output logic [NUM_PADS-1:0]              esel_inv
);

   localparam int unsigned PAD_IW   = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
   localparam int unsigned SEL_END  = SEL_BASE_WORD + 2 * NUM_PADS;

   logic [31:0]       widx;
   acc_kind_e         kind;
   logic [PAD_IW-1:0] pidx;
   logic [31:0]       rel;

   // Address decode
   always_comb begin
      widx = 32'(bus_addr[ADDR_W-1:2]);
      rel  = widx - SEL_BASE_WORD;
      kind = ACC_NONE;
      pidx = '0;
      if (widx == IN_LO_WORD || widx == IN_HI_WORD) begin
         kind = ACC_STATUS;
      end else if (widx >= SEL_BASE_WORD && widx < SEL_END) begin
         kind = widx[0] ? ACC_ESEL : ACC_DSEL;
         pidx = PAD_IW'(rel >> 1);
      end
   end

   // Select storage: only the code field and the invert flag are kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < int'(NUM_PADS); p++) begin
            dsel_code[p] <= '0;
            dsel_inv[p]  <= 1'b0;
            esel_code[p] <= SEL_W'(1);
            esel_inv[p]  <= 1'b0;
         end
      end else if (bus_we) begin
         for (int p = 0; p < int'(NUM_PADS); p++) begin
            if (pidx == PAD_IW'(p)) begin
               if (kind == ACC_DSEL) begin
                  dsel_code[p] <= bus_wdata[SEL_W-1:0];
                  dsel_inv[p]  <= bus_wdata[INV_BIT];
               end
               if (kind == ACC_ESEL) begin
                  esel_code[p] <= bus_wdata[SEL_W-1:0];
                  esel_inv[p]  <= bus_wdata[INV_BIT];
               end
            end
         end
      end
   end

   // Same-cycle read mux
   always_comb begin
      bus_rdata = '0;
      unique case (kind)
         ACC_STATUS: bus_rdata = widx[0] ? status_hi : status_lo;
         ACC_DSEL: begin
            bus_rdata[INV_BIT]   = dsel_inv[pidx];
            bus_rdata[SEL_W-1:0] = dsel_code[pidx];
         end
         ACC_ESEL: begin
            bus_rdata[INV_BIT]   = esel_inv[pidx];
            bus_rdata[SEL_W-1:0] = esel_code[pidx];
         end
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_route_bank.sv
module gpio_route_bank
   import gpio_route_pkg::*;
#(
   parameter int unsigned NUM_PADS    = 64,
   parameter int unsigned NUM_PERIPH  = 20,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_PERIPH-1:0] periph_do,
   input  logic [NUM_PERIPH-1:0] periph_de,
   input  logic [NUM_PADS-1:0]   pad_in,
   output logic [NUM_PADS-1:0]   pad_out,
   output logic [NUM_PADS-1:0]   pad_oe_n
);

   localparam int unsigned SEL_W = $clog2(NUM_PERIPH + 2);

   if (NUM_PADS < 1 || NUM_PADS > 64) begin : g_bad_pads
      $error("gpio_route_bank: NUM_PADS must be 1..64");
   end
   if (NUM_PERIPH < 1 || SEL_W > 30) begin : g_bad_periph
      $error("gpio_route_bank: NUM_PERIPH out of range");
   end
   if ((4 * (SEL_BASE_WORD + 2 * NUM_PADS)) > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_route_bank: ADDR_W too small for the register map");
   end

   logic [NUM_PADS-1:0][SEL_W-1:0] dsel_code;
   logic [NUM_PADS-1:0]            dsel_inv;
   logic [NUM_PADS-1:0][SEL_W-1:0] esel_code;
   logic [NUM_PADS-1:0]            esel_inv;
   logic [NUM_PADS-1:0]            in_sync;
   logic [63:0]                    in_wide;

   gpio_route_sync #(
      .WIDTH (NUM_PADS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (in_sync)
   );

   assign in_wide = 64'(in_sync);

   gpio_route_regs #(
      .NUM_PADS(NUM_PADS),
      .SEL_W   (SEL_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .status_lo(in_wide[31:0]),
      .status_hi(in_wide[63:32]),
      .dsel_code(dsel_code),
      .dsel_inv (dsel_inv),
      .esel_code(esel_code),
      .esel_inv (esel_inv)
   );

   for (genvar p = 0; p < int'(NUM_PADS); p++) begin : g_pad
      gpio_route_srcmux #(
         .NUM_SRC(NUM_PERIPH),
         .SEL_W  (SEL_W)
      ) u_dmux (
         .code(dsel_code[p]),
         .inv (dsel_inv[p]),
         .src (periph_do),
         .y   (pad_out[p])
      );

      gpio_route_srcmux #(
         .NUM_SRC(NUM_PERIPH),
         .SEL_W  (SEL_W)
      ) u_emux (
         .code(esel_code[p]),
         .inv (esel_inv[p]),
         .src (periph_de),
         .y   (pad_oe_n[p])
      );
   end

endmodule

// File: rtl/gpio_route_bank_chk.sv
module gpio_route_bank_chk #(
   parameter int unsigned NUM_PADS    = 64,
   parameter int unsigned NUM_PERIPH  = 20,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  bus_we,
   input logic [31:0]           bus_wdata,
   input logic [31:0]           bus_rdata,
   input logic [NUM_PERIPH-1:0] periph_do,
   input logic [NUM_PERIPH-1:0] periph_de,
   input logic [NUM_PADS-1:0]   pad_in,
   input logic [NUM_PADS-1:0]   pad_out,
   input logic [NUM_PADS-1:0]   pad_oe_n
);

   localparam int unsigned SEL_W  = $clog2(NUM_PERIPH + 2);
   localparam int unsigned PAD_IW = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
   localparam logic [31:0] RSV_MASK = ~(32'h8000_0000 | ((32'd1 << SEL_W) - 32'd1));

   logic [31:0]       widx;
   logic              is_sel;
   logic              is_stat;
   logic              unmapped;
   logic [PAD_IW-1:0] wpad;
   logic [63:0]       pin_wide;
   logic              any_wr;
   logic [1:0]        age;

   assign widx     = 32'(bus_addr[ADDR_W-1:2]);
   assign is_stat  = (widx == 32'd18) || (widx == 32'd19);
   assign is_sel   = (widx >= 32'd20) && (widx < 32'(20 + 2 * NUM_PADS));
   assign unmapped = !is_stat && !is_sel;
   assign wpad     = PAD_IW'((widx - 32'd20) >> 1);
   assign pin_wide = 64'(pad_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         any_wr <= 1'b0;
         age    <= '0;
      end else begin
         if (bus_we) any_wr <= 1'b1;
         if (age != 2'd3) age <= age + 2'd1;
      end
   end

   // R1
   reset_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_wr |-> (pad_oe_n == '1 && pad_out == '0));

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> bus_rdata == 32'd0);

   // R3
   sel_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_sel |-> (bus_rdata & RSV_MASK) == 32'd0);

   // R4
   const_one_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && is_sel && !widx[0] && bus_wdata == 32'd1) |=> pad_out[$past(wpad)]);

   // R8
   enable_low_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && is_sel && widx[0] && bus_wdata == 32'd0) |=> !pad_oe_n[$past(wpad)]);

   if (SYNC_STAGES == 2) begin : g_sync_chk
      // R9
      status_lo_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (age == 2'd3 && widx == 32'd18) |-> bus_rdata == $past(pin_wide[31:0], 2));
   end

endmodule

bind gpio_route_bank gpio_route_bank_chk #(
   .NUM_PADS   (NUM_PADS),
   .NUM_PERIPH (NUM_PERIPH),
   .ADDR_W     (ADDR_W),
   .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/gpio_route_bank_bench.sv
module gpio_route_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [19:0] periph_do = '0;
   logic [19:0] periph_de = '0;
   logic [63:0] pad_in = '0;
   logic [63:0] pad_out;
   logic [63:0] pad_oe_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   gpio_route_bank u_gpio_route_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .periph_do(periph_do),
      .periph_de(periph_de),
      .pad_in   (pad_in),
      .pad_out  (pad_out),
      .pad_oe_n (pad_oe_n)
   );

   // {byte address, write data, expected readback}
   localparam int NVEC = 12;
   localparam logic [75:0] VEC [NVEC] = '{
      {12'h050, 32'h0000_0003, 32'h0000_0003},   // R2 pad 0 data
      {12'h054, 32'h0000_0000, 32'h0000_0000},   // R2 pad 0 enable
      {12'h1F8, 32'h0000_0011, 32'h0000_0011},   // R2 pad 53 data
      {12'h1FC, 32'h8000_0000, 32'h8000_0000},   // R2 pad 53 enable
      {12'h248, 32'h0000_000A, 32'h0000_000A},   // R2 pad 63 data
      {12'h24C, 32'h0000_0001, 32'h0000_0001},   // R2 pad 63 enable
      {12'h058, 32'hFFFF_FFFF, 32'h8000_001F},   // R3 reserved bits
      {12'h05C, 32'h7FFF_FFE0, 32'h0000_0000},   // R3 reserved only
      {12'h048, 32'hFFFF_FFFF, 32'h0000_0000},   // R10 status write
      {12'h250, 32'h1234_5678, 32'h0000_0000},   // R10 past the map
      {12'h040, 32'hFFFF_FFFF, 32'h0000_0000},   // R10 below the map
      {12'h FFC, 32'hFFFF_FFFF, 32'h0000_0000}   // R10 top of space
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      // R1: held in reset
      repeat (2) @(negedge clk);
      rd(12'h078, r);
      chk(r == 32'h0, "R1 data select in reset", r, 32'h0);
      chk(pad_oe_n == '1, "R1 oe_n in reset", pad_oe_n, '1);
      rst_n = 1'b1;
      @(negedge clk);
      rd(12'h07C, r);
      chk(r == 32'h1, "R1 enable select after reset", r, 32'h1);
      chk(pad_out == '0, "R1 pad_out after reset", pad_out, '0);
      chk(pad_oe_n == '1, "R1 oe_n after reset", pad_oe_n, '1);

      // Table of write/readback vectors (R2 R3 R10)
      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][75:64], VEC[i][63:32]);
         rd(VEC[i][75:64], r);
         chk(r == VEC[i][31:0], "R2/R3/R10 table readback", r, VEC[i][31:0]);
      end
      rd(12'h248, r);
      chk(r == 32'h0000_000A, "R10 pad 63 untouched by unmapped write", r, 32'hA);

      // R4 constants on pad 5
      wr(12'h078, 32'h1);
      chk(pad_out[5] == 1'b1, "R4 code 1", pad_out[5], 1);
      chk(pad_out[4] == 1'b0 && pad_out[6] == 1'b0, "R2 neighbours untouched",
          pad_out[6:4], 3'b000);
      wr(12'h078, 32'h0);
      chk(pad_out[5] == 1'b0, "R4 code 0", pad_out[5], 0);

      // R5 peripheral routing
      wr(12'h078, 32'd9);
      periph_do = ~(20'd1 << 7); #1;
      chk(pad_out[5] == 1'b0, "R5 src 7 low", pad_out[5], 0);
      periph_do = 20'd1 << 7; #1;
      chk(pad_out[5] == 1'b1, "R5 src 7 high", pad_out[5], 1);
      wr(12'h078, 32'd21);
      periph_do = 20'h80000; #1;
      chk(pad_out[5] == 1'b1, "R5 top code 21", pad_out[5], 1);

      // R6 out-of-range codes
      periph_do = '1;
      wr(12'h078, 32'd22);
      chk(pad_out[5] == 1'b0, "R6 code 22", pad_out[5], 0);
      wr(12'h078, 32'd31);
      chk(pad_out[5] == 1'b0, "R6 code 31", pad_out[5], 0);

      // R7 invert
      wr(12'h078, 32'h8000_0016);
      chk(pad_out[5] == 1'b1, "R7 invert of out-of-range", pad_out[5], 1);
      wr(12'h078, 32'h8000_0001);
      chk(pad_out[5] == 1'b0, "R7 invert of const 1", pad_out[5], 0);

      // R8 active-low enable
      wr(12'h07C, 32'h0);
      chk(pad_oe_n[5] == 1'b0, "R8 enable code 0 drives", pad_oe_n[5], 0);
      chk(pad_oe_n[4] == 1'b1, "R2 pad 4 enable untouched", pad_oe_n[4], 1);
      wr(12'h07C, 32'd5);
      periph_de = 20'd1 << 3; #1;
      chk(pad_oe_n[5] == 1'b1, "R5/R8 enable src 3 high", pad_oe_n[5], 1);
      periph_de = '0; #1;
      chk(pad_oe_n[5] == 1'b0, "R5/R8 enable src 3 low", pad_oe_n[5], 0);
      wr(12'h07C, 32'h8000_0000);
      chk(pad_oe_n[5] == 1'b1, "R7 inverted enable", pad_oe_n[5], 1);

      // R9 input status after the synchronizer
      @(negedge clk);
      pad_in = 64'hA5A5_0000_1234_5678;
      rd(12'h048, r);
      chk(r == 32'h0, "R9 no edge yet", r, 32'h0);
      @(negedge clk);
      rd(12'h048, r);
      chk(r == 32'h0, "R9 one edge", r, 32'h0);
      @(negedge clk);
      rd(12'h048, r);
      chk(r == 32'h1234_5678, "R9 low word two edges", r, 32'h1234_5678);
      rd(12'h04C, r);
      chk(r == 32'hA5A5_0000, "R9 high word", r, 32'hA5A5_0000);

      // R10 write to status ignored
      wr(12'h04C, 32'h0);
      rd(12'h04C, r);
      chk(r == 32'hA5A5_0000, "R10 status write ignored", r, 32'hA5A5_0000);

      // R1 reset in the middle of operation
      @(negedge clk);
      rst_n = 1'b0; #1;
      rd(12'h078, r);
      chk(r == 32'h0, "R1 data select cleared", r, 32'h0);
      rd(12'h07C, r);
      chk(r == 32'h1, "R1 enable select restored", r, 32'h1);
      chk(pad_oe_n == '1, "R1 all tristated", pad_oe_n, '1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule